// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block provides a small set of independent 32-bit down counters behind a flat 32-bit register bus. Software programs an interval, picks a tick source and a power-of-two divider, and starts a channel. The channel then counts down on each divided tick. When it reaches its terminal count it either reloads the interval (periodic mode) or halts (single-shot mode). Each expiry raises a per-channel pending flag in a shared status word. A shared enable word decides which pending flags drive the single level interrupt line.

Each channel is run by a two-state machine. The states are `CH_STOPPED` and `CH_COUNTING`:
- **START**: a control write with the enable bit set moves `CH_STOPPED` to `CH_COUNTING`.
- **HALT**: a control write with the enable bit clear moves `CH_COUNTING` to `CH_STOPPED`.
- **FINISH**: a single-shot expiry moves `CH_COUNTING` to `CH_STOPPED`.

Any other cycle keeps the current state. Tick sources arrive as one-cycle enable inputs rather than real clocks.

A low-speed oscillator selection word also sits on the bus. It holds only a source-select bit and an auto-switch bit, and it accepts a write only when the write carries the correct 16-bit key in its upper half.

Top module: `mtimer_unit`

## Requirements
- R1: After reset, every mapped register reads zero and `irq` is low.
- R2: Channel n (from 0) occupies byte offsets 0x10+0x10·n (control), +0x4 (interval, read/write) and +0x8 (current value, read-only). The enable word is at 0x00, the status word at 0x04 and the oscillator word at 0x100. Any other offset, including +0xC inside a channel and the block just past the last channel, reads zero and ignores writes.
- R3: The control word layout is as follows:
  - bit 0: enable; it reads back as 1 while the channel is counting.
  - bit 1: reload; a strobe that always reads 0.
  - bits 3:2: tick source; 0 = every clock, 1 = `tick_fast`, 2 = `tick_alt`, 3 = no tick.
  - bits 6:4: prescale.
  - bit 7: single-shot when 1.
- R4: A control write with enable=1 and reload=1 loads the interval into the current value at that clock edge. A write with enable=1 and reload=0 resumes from the held value. Reload without enable loads nothing.
- R5: A counting channel decrements by one on every 2^prescale-th selected tick, counted from its last control write. A stopped channel's current value does not change.
- R6: In periodic mode, a step taken while the current value is 0 or 1 is an expiry. The expiry reloads the interval, so the period is exactly `interval` steps.
- R7: In single-shot mode, an expiry leaves the current value at 0 and clears the enable bit. The channel then stays stopped.
- R8: An expiry sets that channel's status bit whether or not its interrupt is enabled. Writing 1 to a status bit clears it and writing 0 leaves it. A set and a clear in the same cycle leave the bit set.
- R9: `irq` is high exactly while some channel has both its status bit and its enable bit set, with no added delay.
- R10: The oscillator word keeps bit 14 (auto-switch) and bit 0 (select). A write takes effect only when bits 31:16 equal 0x16AA, and those key bits always read back as zero.
- R11: With interval 0xFFFFFFFF, periodic mode and a tick every clock, the bitwise inverse of the current value equals the number of clocks since the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_fast | input | 1 | Tick enable of the fast source (source 1) |
| tick_alt | input | 1 | Tick enable of the alternate source (source 2) |
| irq | output | 1 | Level interrupt: any enabled channel pending |

## Verification
A write lands at the clock edge that ends its bus cycle, and reads are combinational, so a register written at edge E reads back in the same low phase after E. A channel started at edge E holds `interval` right after E and takes its first step at E+1. After k more edges it therefore reads interval − floor(k / 2^prescale), and a periodic expiry with status set appears right after edge E+interval. The bench counts edges by falling edges after each write and samples only in the low phase before the next rising edge. Every expected count, expiry edge and `irq` level is computed from these rules, and the bench sweeps all prescale values, all four tick sources and every channel's address block.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
    localparam int REG_W = 32;
    localparam logic [15:0] OSC_KEY = 16'h16AA;

    typedef enum logic [1:0] {
        SRC_SYS  = 2'd0,
        SRC_FAST = 2'd1,
        SRC_ALT  = 2'd2,
        SRC_NONE = 2'd3
    } tick_src_e;

    typedef enum logic {
        CH_STOPPED  = 1'b0,
        CH_COUNTING = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic      oneshot;
        logic [2:0] prescale;
        tick_src_e src;
    } ch_cfg_t;
endpackage

// File: rtl/mtimer_channel.sv
module mtimer_channel
    import mtimer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             intv_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             tick_fast,
    input  logic             tick_alt,
    output logic [REG_W-1:0] ctrl_rd,
    output logic [REG_W-1:0] intv_rd,
    output logic [REG_W-1:0] cur_rd,
    output logic             expire
);
    localparam int DIV_W = (1 << PS_W) - 1;

    ch_state_e         state, state_nx;
    ch_cfg_t           cfg;
    logic [CNT_W-1:0]  intv, cnt;
    logic [DIV_W-1:0]  pre_cnt, div_mask;
    logic              tick_sel, step, at_end;

    always_comb begin
        unique case (cfg.src)
            SRC_SYS:  tick_sel = 1'b1;
            SRC_FAST: tick_sel = tick_fast;
            SRC_ALT:  tick_sel = tick_alt;
            SRC_NONE: tick_sel = 1'b0;
        endcase
    end

    assign div_mask = (DIV_W'(1) << cfg.prescale) - DIV_W'(1);
    assign step     = (state == CH_COUNTING) && !ctrl_we && tick_sel && (pre_cnt == div_mask);
    assign at_end   = (cnt[CNT_W-1:1] == '0);
    assign expire   = step && at_end;

    // next-state logic: START, HALT, FINISH
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_STOPPED:  if (ctrl_we && wdata[0]) state_nx = CH_COUNTING;
            CH_COUNTING: begin
                if (ctrl_we && !wdata[0])        state_nx = CH_STOPPED;
                else if (expire && cfg.oneshot)  state_nx = CH_STOPPED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_STOPPED;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            intv    <= '0;
            cnt     <= '0;
            pre_cnt <= '0;
        end else begin
            if (intv_we) intv <= wdata[CNT_W-1:0];
            if (ctrl_we) begin
                cfg.oneshot  <= wdata[7];
                cfg.prescale <= wdata[6:4];
                cfg.src      <= tick_src_e'(wdata[3:2]);
                pre_cnt      <= '0;
                if (wdata[0] && wdata[1]) cnt <= intv;
            end else if (state == CH_COUNTING && tick_sel) begin
                pre_cnt <= step ? '0 : pre_cnt + DIV_W'(1);
            end
            if (step) begin
                if (!at_end)          cnt <= cnt - CNT_W'(1);
                else if (cfg.oneshot) cnt <= '0;
                else                  cnt <= intv;
            end
        end
    end

    assign ctrl_rd = {24'b0, cfg.oneshot, cfg.prescale, cfg.src, 1'b0, (state == CH_COUNTING)};
    assign intv_rd = REG_W'(intv);
    assign cur_rd  = REG_W'(cnt);

    // R5
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_STOPPED && !ctrl_we) |=> $stable(cnt));
    // R6
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cfg.oneshot) |=> (cnt == $past(intv)));
    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && cfg.oneshot) |=> (state == CH_STOPPED && cnt == '0));
endmodule

// File: rtl/mtimer_oscreg.sv
module mtimer_oscreg
    import mtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [15:0]      key,
    input  logic             auto_in,
    input  logic             sel_in,
    output logic [REG_W-1:0] rd
);
    logic auto_sw, src_sel, key_ok;

    assign key_ok = (key == OSC_KEY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_sw <= 1'b0;
            src_sel <= 1'b0;
        end else if (we && key_ok) begin
            auto_sw <= auto_in;
            src_sel <= sel_in;
        end
    end

    assign rd = {17'b0, auto_sw, 13'b0, src_sel};

    // R10
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !key_ok) |=> $stable(rd));
endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
    import mtimer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_alt,
    output logic              irq
);
    localparam int BLK_W   = ADDR_W - 4;
    localparam int EN_OFF  = 'h000;
    localparam int ST_OFF  = 'h004;
    localparam int OSC_OFF = 'h100;

    logic [BLK_W-1:0]  blk;
    logic [3:0]        word;
    logic [NUM_CH-1:0] irq_en, irq_pend, ch_expire, ctrl_we, intv_we;
    logic [REG_W-1:0]  ch_rd [NUM_CH];
    logic [REG_W-1:0]  osc_rd;
    logic              en_we, st_we, osc_we;

    assign blk    = bus_addr[ADDR_W-1:4];
    assign word   = bus_addr[3:0];
    assign en_we  = bus_wr && (bus_addr == ADDR_W'(EN_OFF));
    assign st_we  = bus_wr && (bus_addr == ADDR_W'(ST_OFF));
    assign osc_we = bus_wr && (bus_addr == ADDR_W'(OSC_OFF));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic             hit;
        logic [REG_W-1:0] c_rd, i_rd, v_rd;
        assign hit        = (blk == BLK_W'(n + 1));
        assign ctrl_we[n] = bus_wr && hit && (word == 4'h0);
        assign intv_we[n] = bus_wr && hit && (word == 4'h4);

        mtimer_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .ctrl_we(ctrl_we[n]), .intv_we(intv_we[n]), .wdata(bus_wdata),
            .tick_fast(tick_fast), .tick_alt(tick_alt),
            .ctrl_rd(c_rd), .intv_rd(i_rd), .cur_rd(v_rd),
            .expire(ch_expire[n])
        );

        assign ch_rd[n] = !hit          ? '0 :
                          (word == 4'h0) ? c_rd :
                          (word == 4'h4) ? i_rd :
                          (word == 4'h8) ? v_rd : '0;

        // R8
        pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_expire[n] |=> irq_pend[n]);
        // R8
        w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_we && bus_wdata[n] && !ch_expire[n]) |=> !irq_pend[n]);
    end

    mtimer_oscreg u_osc (
        .clk(clk), .rst_n(rst_n), .we(osc_we),
        .key(bus_wdata[31:16]), .auto_in(bus_wdata[14]), .sel_in(bus_wdata[0]),
        .rd(osc_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= '0;
            irq_pend <= '0;
        end else begin
            if (en_we) irq_en <= bus_wdata[NUM_CH-1:0];
            irq_pend <= (irq_pend & ~(st_we ? bus_wdata[NUM_CH-1:0] : '0)) | ch_expire;
        end
    end

    assign irq = |(irq_pend & irq_en);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(EN_OFF))       bus_rdata = REG_W'(irq_en);
        else if (bus_addr == ADDR_W'(ST_OFF))  bus_rdata = REG_W'(irq_pend);
        else if (bus_addr == ADDR_W'(OSC_OFF)) bus_rdata = osc_rd;
        for (int n = 0; n < NUM_CH; n++) bus_rdata = bus_rdata | ch_rd[n];
    end

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (irq_en != '0));
endmodule

// File: tb/mtimer_unit_tb.sv
module mtimer_unit_tb;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_alt = 1'b0;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;

    always #4 clk = ~clk;

    mtimer_unit #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_fast(tick_fast), .tick_alt(tick_alt), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_edges(input int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic logic [8:0] chb(input int n);
        return 9'(16 + 16 * n);
    endfunction

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog act=timeout exp=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, held;
        wait_edges(3);
        rst_n = 1'b1;

        // R1 reset state
        for (int n = 0; n < NCH; n++) begin
            rd(chb(n), v);       chk("R1 ctrl", v, 0);
            rd(chb(n) + 4, v);   chk("R1 intv", v, 0);
            rd(chb(n) + 8, v);   chk("R1 cur", v, 0);
        end
        rd(9'h000, v); chk("R1 en", v, 0);
        rd(9'h004, v); chk("R1 status", v, 0);
        rd(9'h100, v); chk("R1 osc", v, 0);
        chk("R1 irq", 32'(irq), 0);

        // R2 / R3 / R4 map, layout, reload without enable
        for (int n = 0; n < NCH; n++) begin
            wr(chb(n) + 4, 32'hA500_0000 + 32'(n));
            wr(chb(n), 32'h0000_00F6);
            rd(chb(n) + 4, v); chk("R2 intv readback", v, 32'hA500_0000 + 32'(n));
            rd(chb(n), v);     chk("R3 ctrl readback", v, 32'h0000_00F4);
            rd(chb(n) + 8, v); chk("R4 reload w/o enable", v, 0);
            wr(chb(n) + 8, 32'h1234_5678);
            rd(chb(n) + 8, v); chk("R2 cur read-only", v, 0);
            wr(chb(n) + 12, 32'hFFFF_FFFF);
            rd(chb(n) + 12, v); chk("R2 hole", v, 0);
            wr(chb(n), 32'h0);
        end
        wr(chb(NCH), 32'hFFFF_FFFF);     rd(chb(NCH), v);     chk("R2 past last ch", v, 0);
        wr(chb(NCH) + 4, 32'hFFFF_FFFF); rd(chb(NCH) + 4, v); chk("R2 past last intv", v, 0);
        wr(9'h00C, 32'hFFFF_FFFF);       rd(9'h00C, v);       chk("R2 0x0C", v, 0);
        wr(9'h104, 32'hFFFF_FFFF);       rd(9'h104, v);       chk("R2 0x104", v, 0);

        // R5 prescale sweep on channel 1
        wr(chb(1) + 4, 32'd1000);
        for (int ps = 0; ps < 8; ps++) begin
            wr(chb(1), 32'(ps << 4) | 32'h3);
            rd(chb(1), v); chk("R3 enable reads 1", v, 32'(ps << 4) | 32'h1);
            wait_edges(300);
            rd(chb(1) + 8, v);
            chk($sformatf("R5 prescale %0d", ps), v, 32'd1000 - (32'd300 >> ps));
        end
        wr(chb(1), 32'h0);
        rd(chb(1) + 8, held);
        wait_edges(10);
        rd(chb(1) + 8, v); chk("R5 stopped holds", v, held);
        wr(chb(1), 32'h1);
        wait_edges(5);
        rd(chb(1) + 8, v); chk("R4 resume without reload", v, held - 5);
        wr(chb(1), 32'h0);

        // R3 / R5 tick sources on channel 2
        wr(chb(2) + 4, 32'd100);
        wr(chb(2), 32'h7);
        for (int i = 0; i < 30; i++) begin
            tick_fast = (i % 3 == 0); tick_alt = 1'b1; @(negedge clk);
        end
        tick_fast = 1'b0; tick_alt = 1'b0;
        rd(chb(2) + 8, v); chk("R3 fast source", v, 32'd90);
        wr(chb(2), 32'hB);
        for (int i = 0; i < 30; i++) begin
            tick_alt = (i % 2 == 0); tick_fast = 1'b1; @(negedge clk);
        end
        tick_fast = 1'b0; tick_alt = 1'b0;
        rd(chb(2) + 8, v); chk("R3 alt source", v, 32'd85);
        wr(chb(2), 32'hF);
        for (int i = 0; i < 30; i++) begin
            tick_alt = 1'b1; tick_fast = 1'b1; @(negedge clk);
        end
        tick_fast = 1'b0; tick_alt = 1'b0;
        rd(chb(2) + 8, v); chk("R3 no-tick source", v, 32'd100);
        wr(chb(2), 32'h0);

        // R6 / R8 periodic expiry, status without enable
        wr(9'h004, 32'hFFFF_FFFF);
        wr(chb(0) + 4, 32'd10);
        wr(chb(0), 32'h3);
        wait_edges(9);
        rd(9'h004, v); chk("R6 no expiry yet", v, 0);
        rd(chb(0) + 8, v); chk("R6 count before end", v, 32'd1);
        wait_edges(1);
        rd(9'h004, v); chk("R8 status set unenabled", v, 32'h1);
        rd(chb(0) + 8, v); chk("R6 reload", v, 32'd10);
        chk("R9 irq masked", 32'(irq), 0);
        wait_edges(9);
        rd(chb(0) + 8, v); chk("R6 period 2 before", v, 32'd1);
        wait_edges(1);
        rd(chb(0) + 8, v); chk("R6 period 2 reload", v, 32'd10);
        wr(chb(0), 32'h0);
        wr(9'h004, 32'h0);
        rd(9'h004, v); chk("R8 write 0 keeps", v, 32'h1);
        wr(9'h004, 32'h1);
        rd(9'h004, v); chk("R8 write 1 clears", v, 0);

        // R7 / R9 single-shot with interrupt
        wr(9'h000, 32'h1);
        wr(chb(0) + 4, 32'd5);
        wr(chb(0), 32'h83);
        wait_edges(4);
        chk("R9 irq low before", 32'(irq), 0);
        rd(chb(0) + 8, v); chk("R7 count before end", v, 32'd1);
        wait_edges(1);
        chk("R9 irq high", 32'(irq), 1);
        rd(chb(0) + 8, v); chk("R7 ends at zero", v, 0);
        rd(chb(0), v);     chk("R7 enable cleared", v, 32'h80);
        wait_edges(10);
        rd(chb(0) + 8, v); chk("R7 stays stopped", v, 0);
        wr(9'h000, 32'h0);
        chk("R9 irq masked off", 32'(irq), 0);
        rd(9'h004, v); chk("R9 status kept", v, 32'h1);
        wr(9'h000, 32'h1);
        chk("R9 irq re-enabled", 32'(irq), 1);
        wr(9'h004, 32'h1);
        chk("R9 irq after clear", 32'(irq), 0);

        // R10 oscillator key
        wr(9'h100, 32'h16AA_4001);
        rd(9'h100, v); chk("R10 keyed write", v, 32'h0000_4001);
        wr(9'h100, 32'h1234_0000);
        rd(9'h100, v); chk("R10 bad key ignored", v, 32'h0000_4001);
        wr(9'h100, 32'h16AA_4000);
        rd(9'h100, v); chk("R10 keyed partial", v, 32'h0000_4000);
        wr(9'h100, 32'h16AA_0000);
        rd(9'h100, v); chk("R10 keyed clear", v, 0);

        // R11 free-running up count
        wr(chb(0) + 4, 32'hFFFF_FFFF);
        wr(chb(0), 32'h3);
        wait_edges(20);
        rd(chb(0) + 8, v); chk("R11 inverse count", ~v, 32'd20);
        wait_edges(37);
        rd(chb(0) + 8, v); chk("R11 inverse count later", ~v, 32'd57);

        finish_run();
    end
endmodule